// File: doc/BRIEF.md
# ECN Congestion Marker for an Egress Queue

This block sits beside one egress queue of a switch port and judges every departing packet against how full that queue is. For each packet it chooses one of three outcomes: forward the packet untouched, forward it with its two-bit ECN field rewritten to Congestion Experienced (11), or drop it. The choice compares the queue's packet count with three programmable limits: a marking floor, a full-marking level and a hard drop level.

Between the floor and the full-marking level, marking is random. The chance of marking grows in a straight line with how far the occupancy sits above the floor. A free-running 16-bit LFSR supplies the random value, and the compare is done without a divider. Packets that do not take part in ECN (codepoint 00) are never rewritten. Packets that already carry 11 pass as they are. Two saturating counters record how many packets were newly marked and how many were dropped. The ToS byte is taken from the packet-valid strobe, and the decision appears one clock later.

Top module: `ecn_queue_marker`

## Requirements
- R1: Bits [7:2] of the ToS byte (the DSCP part) leave the block exactly as they came in, for every packet.
- R2: When the queue count is less than or equal to the floor threshold, the packet is forwarded, and its ToS byte is not changed.
- R3: When the count is above the floor and at or below the effective full-marking level, a packet whose ECN bits are 01 or 10 is either left unchanged or has its ECN bits set to 11. The marking probability is (count − floor)/(full − floor). At count equal to the full level, every such packet is marked.
- R4: When the count is above the effective full-marking level and at or below the effective drop level, every packet with ECN bits 01 or 10 is forwarded with its ECN bits set to 11.
- R5: When the count is above the effective drop level, the packet is dropped, whatever its ECN bits hold. Dropping takes priority over marking.
- R6: A packet with ECN bits 00 is never marked. It is forwarded unchanged unless R5 drops it.
- R7: A packet with ECN bits 11 leaves with 11. It does not advance the mark counter.
- R8: The effective full-marking level is the larger of the full threshold and the floor. The effective drop level is the larger of the drop threshold and the floor.
- R9: The output valid pulses exactly one clock after each input strobe and at no other time. The output ToS byte and drop flag belong to that packet.
- R10: The mark counter goes up by one for each packet whose ECN bits are changed from 01 or 10 to 11, and it holds at its all-ones value.
- R11: The drop counter goes up by one for each dropped packet, and it holds at its all-ones value.
- R12: After reset, the output valid is low and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid_i | input | 1 | Strobe: a packet is departing this cycle |
| pkt_tos_i | input | 8 | IPv4 ToS byte of the departing packet |
| queue_count_i | input | QCNT_W | Current packet count of the queue |
| thr_min_i | input | QCNT_W | Floor threshold where marking starts |
| thr_max_i | input | QCNT_W | Level above which all capable packets are marked |
| thr_drop_i | input | QCNT_W | Level above which packets are dropped |
| out_valid_o | output | 1 | Decision valid, one cycle after the strobe |
| out_tos_o | output | 8 | ToS byte, possibly with ECN set to 11 |
| out_drop_o | output | 1 | 1 = drop the packet, 0 = forward it |
| mark_count_o | output | CNT_W | Saturating count of newly marked packets |
| drop_count_o | output | CNT_W | Saturating count of dropped packets |

## Verification
A faulty region decode or threshold clamp shows on the very next cycle: a wrong ToS byte or a wrong drop flag appears for that packet. A stuck or badly shaped random source cannot be seen in any single packet. It only shows as a marking rate in the random band that is wrong over a few hundred packets, which is why the bench measures the rate at the middle of the band and just above the floor. A counter that increments on the wrong event, or wraps instead of holding, shows up as soon as the count is compared with the ToS changes and drop flags that were observed.

// File: rtl/ecn_marker_pkg.sv
package ecn_marker_pkg;
   typedef enum logic [1:0] {
      RGN_PASS = 2'd0,
      RGN_RAND = 2'd1,
      RGN_MARK = 2'd2,
      RGN_DROP = 2'd3
   } region_e;

   localparam logic [1:0] ECN_NOT_ECT = 2'b00;
   localparam logic [1:0] ECN_CE      = 2'b11;
endpackage

// File: rtl/ecn_lfsr.sv
module ecn_lfsr #(
   parameter int          W    = 16,
   parameter logic [31:0] SEED = 32'h0000_ACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] rnd_o
);
   localparam logic [W-1:0] SEED_W = W'(SEED);

   logic [W-1:0] state_q;

   generate
      if (SEED_W == '0) begin : g_bad_seed
         $error("ecn_lfsr: seed must be nonzero");
      end
      if (W == 16) begin : g_w16
         localparam logic [W-1:0] TAPS = W'(32'h0000_B400);
         always_ff @(posedge clk) begin
            if (!rst_n) state_q <= SEED_W;
            else        state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
         end
      end else if (W == 24) begin : g_w24
         localparam logic [W-1:0] TAPS = W'(32'h00E1_0000);
         always_ff @(posedge clk) begin
            if (!rst_n) state_q <= SEED_W;
            else        state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
         end
      end else if (W == 32) begin : g_w32
         localparam logic [W-1:0] TAPS = W'(32'h8020_0003);
         always_ff @(posedge clk) begin
            if (!rst_n) state_q <= SEED_W;
            else        state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
         end
      end else begin : g_bad_width
         $error("ecn_lfsr: W must be 16, 24 or 32");
         always_ff @(posedge clk) state_q <= SEED_W;
      end
   endgenerate

   assign rnd_o = state_q;
endmodule

// File: rtl/ecn_region_classify.sv
module ecn_region_classify
   import ecn_marker_pkg::*;
#(
   parameter int QCNT_W   = 16,
   parameter int RND_W    = 16,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic [QCNT_W-1:0] occ_i,
   input  logic [QCNT_W-1:0] thr_min_i,
   input  logic [QCNT_W-1:0] thr_max_i,
   input  logic [QCNT_W-1:0] thr_drop_i,
   input  logic [RND_W-1:0]  rnd_i,
   output region_e           region_o,
   output logic              rand_hit_o
);
   localparam int PROD_W = QCNT_W + RND_W;

   logic [QCNT_W-1:0] eff_max, eff_drop, span, excess;
   logic [PROD_W-1:0] scaled_rnd, scaled_excess;

   generate
      if (CLAMP_EN) begin : g_clamp
         always_comb begin
            eff_max  = (thr_max_i  < thr_min_i) ? thr_min_i : thr_max_i;
            eff_drop = (thr_drop_i < thr_min_i) ? thr_min_i : thr_drop_i;
         end
      end else begin : g_raw
         always_comb begin
            eff_max  = thr_max_i;
            eff_drop = thr_drop_i;
         end
      end
   endgenerate

   // rnd/2^RND_W < excess/span  <=>  rnd*span < excess*2^RND_W
   always_comb begin
      span          = eff_max - thr_min_i;
      excess        = occ_i - thr_min_i;
      scaled_rnd    = PROD_W'(rnd_i) * PROD_W'(span);
      scaled_excess = {excess, {RND_W{1'b0}}};
      rand_hit_o    = scaled_rnd < scaled_excess;
   end

   always_comb begin
      if (occ_i > eff_drop)       region_o = RGN_DROP;
      else if (occ_i > eff_max)   region_o = RGN_MARK;
      else if (occ_i > thr_min_i) region_o = RGN_RAND;
      else                        region_o = RGN_PASS;
   end
endmodule

// File: rtl/ecn_sat_counter.sv
module ecn_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] count_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + W'(1);
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/ecn_queue_marker.sv
module ecn_queue_marker
   import ecn_marker_pkg::*;
#(
   parameter int          QCNT_W    = 16,
   parameter int          CNT_W     = 16,
   parameter int          RND_W     = 16,
   parameter logic [31:0] RND_SEED  = 32'h0000_ACE1,
   parameter bit          CLAMP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid_i,
   input  logic [7:0]        pkt_tos_i,
   input  logic [QCNT_W-1:0] queue_count_i,
   input  logic [QCNT_W-1:0] thr_min_i,
   input  logic [QCNT_W-1:0] thr_max_i,
   input  logic [QCNT_W-1:0] thr_drop_i,
   output logic              out_valid_o,
   output logic [7:0]        out_tos_o,
   output logic              out_drop_o,
   output logic [CNT_W-1:0]  mark_count_o,
   output logic [CNT_W-1:0]  drop_count_o
);
   generate
      if (QCNT_W < 2)  begin : g_chk_q   $error("QCNT_W must be at least 2"); end
      if (CNT_W < 1)   begin : g_chk_c   $error("CNT_W must be at least 1"); end
      if (RND_W < 8)   begin : g_chk_r   $error("RND_W must be at least 8"); end
   endgenerate

   logic [RND_W-1:0] rnd;
   region_e          region;
   logic             rand_hit;
   logic             ect, mark_now, drop_now;

   ecn_lfsr #(.W(RND_W), .SEED(RND_SEED)) lfsr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd_o (rnd)
   );

   ecn_region_classify #(.QCNT_W(QCNT_W), .RND_W(RND_W), .CLAMP_EN(CLAMP_EN)) cls_i (
      .occ_i      (queue_count_i),
      .thr_min_i  (thr_min_i),
      .thr_max_i  (thr_max_i),
      .thr_drop_i (thr_drop_i),
      .rnd_i      (rnd),
      .region_o   (region),
      .rand_hit_o (rand_hit)
   );

   always_comb begin
      ect      = (pkt_tos_i[1:0] != ECN_NOT_ECT) && (pkt_tos_i[1:0] != ECN_CE);
      drop_now = (region == RGN_DROP);
      mark_now = ect && ((region == RGN_MARK) || ((region == RGN_RAND) && rand_hit));
   end

   logic       valid_q, drop_q;
   logic [7:0] tos_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         drop_q  <= 1'b0;
         tos_q   <= '0;
      end else begin
         valid_q <= pkt_valid_i;
         if (pkt_valid_i) begin
            drop_q <= drop_now;
            tos_q  <= mark_now ? {pkt_tos_i[7:2], ECN_CE} : pkt_tos_i;
         end
      end
   end

   ecn_sat_counter #(.W(CNT_W)) mark_cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (pkt_valid_i && mark_now),
      .count_o (mark_count_o)
   );

   ecn_sat_counter #(.W(CNT_W)) drop_cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (pkt_valid_i && drop_now),
      .count_o (drop_count_o)
   );

   assign out_valid_o = valid_q;
   assign out_tos_o   = tos_q;
   assign out_drop_o  = drop_q;
endmodule

// File: rtl/ecn_marker_chk.sv
module ecn_marker_chk #(
   parameter int QCNT_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pkt_valid_i,
   input logic [7:0]        pkt_tos_i,
   input logic [QCNT_W-1:0] queue_count_i,
   input logic [QCNT_W-1:0] thr_min_i,
   input logic [QCNT_W-1:0] thr_drop_i,
   input logic              out_valid_o,
   input logic [7:0]        out_tos_o,
   input logic              out_drop_o,
   input logic [CNT_W-1:0]  mark_count_o,
   input logic [CNT_W-1:0]  drop_count_o
);
   logic [QCNT_W-1:0] drop_lvl;
   assign drop_lvl = (thr_drop_i < thr_min_i) ? thr_min_i : thr_drop_i;

   AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid_i |=> out_valid_o); // R9
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid_i |=> !out_valid_o); // R9
   AST_DSCP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid_i |=> out_tos_o[7:2] == $past(pkt_tos_i[7:2])); // R1
   AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid_i && queue_count_i <= thr_min_i |=> !out_drop_o && out_tos_o == $past(pkt_tos_i)); // R2
   AST_HIGH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid_i && queue_count_i > drop_lvl |=> out_drop_o); // R5
   AST_NOT_ECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid_i && pkt_tos_i[1:0] == 2'b00 |=> out_tos_o[1:0] == 2'b00); // R6
   AST_CE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid_i && pkt_tos_i[1:0] == 2'b11 |=> out_tos_o[1:0] == 2'b11 && $stable(mark_count_o)); // R7
   AST_MARK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> mark_count_o == $past(mark_count_o) || mark_count_o == CNT_W'($past(mark_count_o) + 1'b1)); // R10
   AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> drop_count_o == $past(drop_count_o) || drop_count_o == CNT_W'($past(drop_count_o) + 1'b1)); // R11
endmodule

bind ecn_queue_marker ecn_marker_chk #(.QCNT_W(QCNT_W), .CNT_W(CNT_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .pkt_valid_i   (pkt_valid_i),
   .pkt_tos_i     (pkt_tos_i),
   .queue_count_i (queue_count_i),
   .thr_min_i     (thr_min_i),
   .thr_drop_i    (thr_drop_i),
   .out_valid_o   (out_valid_o),
   .out_tos_o     (out_tos_o),
   .out_drop_o    (out_drop_o),
   .mark_count_o  (mark_count_o),
   .drop_count_o  (drop_count_o)
);

// File: tb/ecn_queue_marker_tb_top.sv
module ecn_queue_marker_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int QW  = 16;
   localparam int CW  = 6;
   localparam int SAT = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pkt_valid_i = 1'b0;
   logic [7:0]    pkt_tos_i = '0;
   logic [QW-1:0] queue_count_i = '0;
   logic [QW-1:0] thr_min_i = '0, thr_max_i = '0, thr_drop_i = '0;
   logic          out_valid_o, out_drop_o;
   logic [7:0]    out_tos_o;
   logic [CW-1:0] mark_count_o, drop_count_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecn_queue_marker #(.QCNT_W(QW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .pkt_valid_i(pkt_valid_i), .pkt_tos_i(pkt_tos_i),
      .queue_count_i(queue_count_i), .thr_min_i(thr_min_i), .thr_max_i(thr_max_i),
      .thr_drop_i(thr_drop_i), .out_valid_o(out_valid_o), .out_tos_o(out_tos_o),
      .out_drop_o(out_drop_o), .mark_count_o(mark_count_o), .drop_count_o(drop_count_o)
   );

   typedef struct packed {
      logic [7:0] tos;   // expected ToS when not randomly marked
      logic       drop;
      logic       mk;    // deterministic new mark
      logic       rnd;   // mark allowed but not required
   } exp_t;

   exp_t  exp_q[$];
   string req_q[$];
   int total = 0, bad = 0;
   int exp_marks = 0, exp_drops = 0, rnd_marks = 0;
   int sent = 0, seen = 0;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int sat(input int v);
      return (v > SAT) ? SAT : v;
   endfunction

   // Model from the requirements (R2..R8)
   function automatic exp_t model(input int q, input logic [7:0] tos);
      exp_t e;
      int lo, hi, dl;
      bit ect;
      lo  = int'(thr_min_i);
      hi  = (int'(thr_max_i)  < lo) ? lo : int'(thr_max_i);   // R8
      dl  = (int'(thr_drop_i) < lo) ? lo : int'(thr_drop_i);  // R8
      ect = (tos[1:0] == 2'b01) || (tos[1:0] == 2'b10);
      e.tos = tos; e.drop = 1'b0; e.mk = 1'b0; e.rnd = 1'b0;
      if (q > dl) e.drop = 1'b1;                               // R5
      else if (q > hi) begin                                   // R4
         if (ect) begin e.tos[1:0] = 2'b11; e.mk = 1'b1; end
      end else if (q > lo) begin                               // R3
         if (ect && q == hi) begin e.tos[1:0] = 2'b11; e.mk = 1'b1; end
         else if (ect) e.rnd = 1'b1;
      end
      return e;
   endfunction

   task automatic set_thr(input int lo, input int hi, input int dl);
      @(negedge clk);
      pkt_valid_i = 1'b0;
      thr_min_i = QW'(lo); thr_max_i = QW'(hi); thr_drop_i = QW'(dl);
   endtask

   task automatic send(input int q, input logic [7:0] tos, input string req);
      @(negedge clk);
      pkt_valid_i   = 1'b1;
      pkt_tos_i     = tos;
      queue_count_i = QW'(q);
      exp_q.push_back(model(q, tos));
      req_q.push_back(req);
      sent++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         pkt_valid_i = 1'b0;
      end
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid_o) begin
         seen++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "output valid with no packet pending", 1, 0);
         end else begin
            exp_t  e;
            string r;
            bit    ok;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(out_tos_o[7:2] == e.tos[7:2], "R1", "dscp bits", out_tos_o[7:2], e.tos[7:2]);
            if (e.rnd) begin
               ok = !out_drop_o && (out_tos_o == e.tos || out_tos_o == {e.tos[7:2], 2'b11});
               check(ok, r, "tos in random band", out_tos_o, e.tos);
               if (out_tos_o[1:0] == 2'b11) begin exp_marks++; rnd_marks++; end
            end else begin
               check(out_tos_o == e.tos, r, "tos", out_tos_o, e.tos);
               check(out_drop_o == e.drop, r, "drop flag", out_drop_o, e.drop);
               if (e.mk)   exp_marks++;
               if (e.drop) exp_drops++;
            end
         end
      end
   end

   task automatic summary;
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "R9", "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check(out_valid_o == 1'b0, "R12", "valid in reset", out_valid_o, 0);
      check(mark_count_o == '0, "R12", "mark count in reset", mark_count_o, 0);
      check(drop_count_o == '0, "R12", "drop count in reset", drop_count_o, 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      check(out_valid_o == 1'b0 && mark_count_o == '0, "R12", "state after reset", out_valid_o, 0);

      set_thr(100, 300, 500);
      // R2: at or below floor
      send(50,  8'h61, "R2"); send(100, 8'h62, "R2");
      send(0,   8'hFC, "R2"); send(100, 8'h63, "R2");
      idle(2);
      // R4 region, with R6 and R7 codepoints
      send(301, 8'h61, "R4"); send(500, 8'h9E, "R4");
      send(400, 8'h60, "R6"); send(450, 8'hA3, "R7");
      idle(1);
      // R3: band top marks every capable packet
      send(300, 8'h62, "R3"); send(300, 8'h05, "R3");
      idle(2);
      check(int'(mark_count_o) == sat(exp_marks), "R10", "mark count", mark_count_o, sat(exp_marks));
      // R5: drop over the limit regardless of codepoint
      send(501, 8'h61, "R5"); send(900, 8'h60, "R5"); send(65535, 8'h63, "R5");
      idle(2);
      check(int'(drop_count_o) == sat(exp_drops), "R11", "drop count", drop_count_o, sat(exp_drops));
      check(int'(mark_count_o) == sat(exp_marks), "R7", "mark count after CE/drops", mark_count_o, sat(exp_marks));

      // R8: misprogrammed thresholds
      set_thr(200, 50, 100);
      send(200, 8'h62, "R8"); send(201, 8'h62, "R8");
      set_thr(200, 100, 400);
      send(201, 8'h61, "R8"); send(400, 8'h62, "R8"); send(401, 8'h61, "R8");
      idle(2);

      // R3: rate near middle of band (expect ~50%)
      set_thr(100, 300, 500);
      rnd_marks = 0;
      for (int i = 0; i < 400; i++) begin send(200, 8'hA2, "R3"); idle(1); end
      idle(2);
      check(rnd_marks >= 120 && rnd_marks <= 280, "R3", "marks of 400 at mid band", rnd_marks, 200);
      // R3: rate just above floor (expect ~0.5%)
      rnd_marks = 0;
      for (int i = 0; i < 400; i++) begin send(101, 8'h41, "R3"); idle(1); end
      idle(2);
      check(rnd_marks <= 12, "R3", "marks of 400 just above floor", rnd_marks, 2);
      // R6: not capable in the band never marked
      for (int i = 0; i < 20; i++) send(299, 8'h80, "R6");
      idle(2);
      check(int'(mark_count_o) == sat(exp_marks), "R10", "mark count saturation", mark_count_o, sat(exp_marks));

      // R11: drive drops past saturation
      for (int i = 0; i < 70; i++) send(600, 8'h02, "R11");
      idle(2);
      check(int'(drop_count_o) == sat(exp_drops), "R11", "drop count saturation", drop_count_o, sat(exp_drops));
      check(drop_count_o == CW'(SAT), "R11", "drop count held at max", drop_count_o, SAT);

      // R9: every packet produced exactly one result
      idle(3);
      check(seen == sent, "R9", "results vs packets", seen, sent);
      check(out_valid_o == 1'b0, "R9", "valid idle", out_valid_o, 0);
      summary();
      $finish;
   end
endmodule